// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog. A down-counter starts from a programmable initial value and steps down once per tick. A prescaler divides the input clock to make the tick, and its default suits a 0.6 second tick at 50 MHz. Software keeps the system alive by writing the reload register, which puts the initial value back into the counter. Software can also stop and restart counting with a halt bit and read the current count.

When the counter runs out the first time, the block raises a timeout flag and starts the count again. If the counter runs out a second time before software has cleared that flag, the block raises two more flags and sends a one-cycle reset request. A no-reboot bit can mask that request. All status flags are cleared by writing 1. A small 16-bit bus reaches the registers. It has word addresses (address bit 0 is ignored), a byte enable per byte, and a read-data path with no delay.

Register offsets: 0x00 reload/count, 0x04 first-timeout status, 0x06 second-stage status, 0x08 control, 0x0C initial value.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control (0x08) reads 0x0801 (halt bit 11 = 1, no-reboot bit 0 = 1). The initial value and the count read 50. Both status registers read 0 and `rst_req` is 0.
- R2: While halt is 0, the count drops by one every TICK_DIV clock cycles. While halt is 1, the count holds its value.
- R3: Any write to offset 0x00 loads the count with the initial value and restarts the tick phase, whatever the data or byte enables. A read of 0x00 returns the current count in the low bits.
- R4: The initial-value field at 0x0C is 10 bits wide (6 bits when LEGACY=1) and each byte is written under its own byte enable. The bits above the field always read 0.
- R5: A write that would make the initial-value field 0, 1, 2 or 3 is ignored, and the previous value stays.
- R6: A tick that finds the count at 0 is an expiry. It sets the timeout flag (bit 3 of 0x04) and reloads the count with the initial value.
- R7: An expiry while the timeout flag is already set also sets the second-timeout flag (bit 1) and the boot flag (bit 2) of 0x06. If no-reboot is 0, `rst_req` is then high for exactly one cycle.
- R8: While no-reboot is 1, a second expiry still sets the status flags but `rst_req` stays 0.
- R9: Writing 1 to a status bit clears it and writing 0 has no effect. An expiry in the same cycle as a clearing write leaves the flag set.
- R10: A reload write in the same cycle as an expiry takes precedence: no flag is set and the count equals the initial value.
- R11: Control bits read back as written. Byte 1 updates halt and byte 0 updates no-reboot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register, bit 0 ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte enables, bit 1 for the upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, no delay |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can land in the same clock edge: a software write and a counter expiry. The bench computes the exact edge of expiry as (N+1)·TICK_DIV cycles after a reload. It then issues a reload write, or a clearing write to the timeout flag, exactly on that edge. The reload case must leave the timeout flag clear with the count at N. The clearing case must leave the flag set.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TICK_DIV = 30_000_000,
  parameter bit          LEGACY   = 1'b0,
  parameter int unsigned INIT_RST = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req
);
  localparam int FW = LEGACY ? 6 : 10;
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [FW-1:0] INIT_DEF = FW'(INIT_RST);
  localparam logic [3:0] IX_RLD = 4'd0, IX_STS1 = 4'd2, IX_STS2 = 4'd3,
                         IX_CTRL = 4'd4, IX_INIT = 4'd6;

  logic [PW-1:0] pre;
  logic [FW-1:0] count, init_val;
  logic halt, no_reboot, sts_to, sts_2nd, sts_boot;

  wire [3:0] idx     = bus_addr[4:1];
  wire wr_rld        = bus_wr && idx == IX_RLD;
  wire wr_sts1       = bus_wr && idx == IX_STS1 && bus_be[0];
  wire wr_sts2       = bus_wr && idx == IX_STS2 && bus_be[0];
  wire wr_ctrl       = bus_wr && idx == IX_CTRL;
  wire wr_init       = bus_wr && idx == IX_INIT;

  wire tick          = !halt && pre == PRE_LAST;
  wire expire        = tick && count == '0 && !wr_rld;

  wire [15:0] init16 = {{(16-FW){1'b0}}, init_val};
  wire [15:0] init_mg = {bus_be[1] ? bus_wdata[15:8] : init16[15:8],
                         bus_be[0] ? bus_wdata[7:0]  : init16[7:0]};
  wire [FW-1:0] init_new = init_mg[FW-1:0];
  wire init_ok       = init_new >= FW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n)           pre <= '0;
    else if (wr_rld)      pre <= '0;
    else if (!halt)       pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= INIT_DEF;
    else if (wr_rld || expire)  count <= init_val;
    else if (tick)              count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_to   <= 1'b0;
      sts_2nd  <= 1'b0;
      sts_boot <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (expire)                          sts_to <= 1'b1;
      else if (wr_sts1 && bus_wdata[3])    sts_to <= 1'b0;
      if (expire && sts_to) begin
        sts_2nd  <= 1'b1;
        sts_boot <= 1'b1;
      end else if (wr_sts2) begin
        if (bus_wdata[1]) sts_2nd  <= 1'b0;
        if (bus_wdata[2]) sts_boot <= 1'b0;
      end
      rst_req <= expire && sts_to && !no_reboot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      no_reboot <= 1'b1;
    end else if (wr_ctrl) begin
      if (bus_be[1]) halt      <= bus_wdata[11];
      if (bus_be[0]) no_reboot <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  init_val <= INIT_DEF;
    else if (wr_init && init_ok) init_val <= init_new;
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IX_RLD:  bus_rdata = {{(16-FW){1'b0}}, count};
      IX_STS1: bus_rdata = {12'b0, sts_to, 3'b0};
      IX_STS2: bus_rdata = {13'b0, sts_boot, sts_2nd, 1'b0};
      IX_CTRL: bus_rdata = {4'b0, halt, 10'b0, no_reboot};
      IX_INIT: bus_rdata = init16;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_rld) |=> $stable(count));
  // R6
  first_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_to) |-> $past(count) == '0);
  // R7
  second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_2nd) |-> $past(sts_to));
  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8
  no_reboot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(no_reboot));
  // R5
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(init_val) |-> init_val >= FW'(4));
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int P = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, rq0, rq1;
  logic [4:0] bus_addr = '0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0, rd0, rd1;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_timer #(.TICK_DIV(P), .LEGACY(1'b0), .INIT_RST(50)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd0), .rst_req(rq0));
  wdog_timer #(.TICK_DIV(P), .LEGACY(1'b1), .INIT_RST(50)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd1), .rst_req(rq1));

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    bus_addr = a;
    #1 v = rd0;
  endtask

  task automatic setup(int n, logic [15:0] ctrl);
    wr(5'h08, 16'h0801, 2'b11);
    wr(5'h04, 16'h0008, 2'b01);
    wr(5'h06, 16'h0006, 2'b01);
    wr(5'h0C, 16'(n), 2'b11);
    wr(5'h08, ctrl, 2'b11);
    wr(5'h00, 16'h5A5A, 2'b10);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int v, prev;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    rd(5'h00, v); chk("R1 count", v, 50);
    rd(5'h04, v); chk("R1 sts1", v, 0);
    rd(5'h06, v); chk("R1 sts2", v, 0);
    rd(5'h08, v); chk("R1 ctrl", v, 16'h0801);
    rd(5'h0C, v); chk("R1 init", v, 50);
    chk("R1 rst_req", int'(rq0), 0);
    // R4
    wr(5'h0C, 16'hFFFF, 2'b11);
    rd(5'h0C, v); chk("R4 main width", v, 16'h03FF);
    chk("R4 legacy width", int'(rd1), 16'h003F);
    wr(5'h0C, 16'h0005, 2'b01);
    rd(5'h0C, v); chk("R4 byte lane", v, 16'h0305);
    // R5 sweep
    prev = 16'h0305;
    for (int i = 0; i < 16; i++) begin
      wr(5'h0C, 16'(i), 2'b11);
      if (i >= 4) prev = i;
      rd(5'h0C, v); chk($sformatf("R5 init %0d", i), v, prev);
    end
    // R11
    wr(5'h08, 16'h0000, 2'b10);
    rd(5'h08, v); chk("R11 halt lane", v, 16'h0001);
    wr(5'h08, 16'h0800, 2'b11);
    rd(5'h08, v); chk("R11 both lanes", v, 16'h0800);
    // R2 halted
    setup(6, 16'h0801);
    repeat (40) @(posedge clk);
    #1 rd(5'h00, v); chk("R2 halted hold", v, 6);
    // R2 R3 R6 R8 sweep over initial values
    for (int n = 4; n <= 7; n++) begin
      setup(n, 16'h0001);
      rd(5'h00, v); chk("R3 reload", v, n);
      for (int k = 1; k <= n; k++) begin
        repeat (P) @(posedge clk);
        #1 rd(5'h00, v); chk($sformatf("R2 n%0d k%0d", n, k), v, n - k);
      end
      bus_addr = 5'h04;
      repeat (P - 1) @(posedge clk);
      #1 rd(5'h04, v); chk("R6 before expiry", v, 0);
      @(posedge clk);
      #1 rd(5'h04, v); chk("R6 flag", v, 8);
      rd(5'h00, v); chk("R6 reloaded", v, n);
      bus_addr = 5'h06;
      repeat (P * (n + 1) - 1) @(posedge clk);
      #1 rd(5'h06, v); chk("R8 before second", v, 0);
      @(posedge clk);
      #1 rd(5'h06, v); chk("R8 second flags", v, 6);
      chk("R8 masked", int'(rq0), 0);
    end
    // R9
    wr(5'h08, 16'h0801, 2'b11);
    wr(5'h04, 16'h0000, 2'b11);
    rd(5'h04, v); chk("R9 zero write", v, 8);
    wr(5'h04, 16'h0008, 2'b01);
    rd(5'h04, v); chk("R9 clear sts1", v, 0);
    wr(5'h06, 16'h0002, 2'b01);
    rd(5'h06, v); chk("R9 clear second", v, 4);
    wr(5'h06, 16'h0004, 2'b01);
    rd(5'h06, v); chk("R9 clear boot", v, 0);
    // R7
    setup(5, 16'h0000);
    bus_addr = 5'h06;
    repeat (P * 6) @(posedge clk);
    repeat (P * 6 - 1) @(posedge clk);
    #1 chk("R7 before pulse", int'(rq0), 0);
    @(posedge clk);
    #1 chk("R7 pulse", int'(rq0), 1);
    rd(5'h06, v); chk("R7 flags", v, 6);
    @(posedge clk);
    #1 chk("R7 one cycle", int'(rq0), 0);
    // R10 reload on the expiry edge
    setup(5, 16'h0001);
    repeat (P * 6 - 1) @(posedge clk);
    wr(5'h00, 16'h0000, 2'b01);
    rd(5'h04, v); chk("R10 no flag", v, 0);
    rd(5'h00, v); chk("R10 count", v, 5);
    // R9 clear on the expiry edge
    setup(5, 16'h0001);
    repeat (P * 6 - 1) @(posedge clk);
    wr(5'h04, 16'h0008, 2'b01);
    rd(5'h04, v); chk("R9 set wins", v, 8);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule